// File: doc/BRIEF.md
# Reset-Hold Duration Meter

This block measures how long an active-low external reset button is held down. It counts cycles of a 25 MHz reference clock while the pin is low, so one count is 40 ns. A 29-bit count covers about 21.4 seconds. The count sits in a register that software reads once the system has come back out of reset. A long hold can then be treated as a request to restore factory settings. The count is not cleared by the reset it measures. Only the power-on reset or an explicit clear write sets it back to zero, and a later low period adds to the stored value.

The pin is asynchronous, so it passes through a two-flop synchroniser before it enables the counter. The counter stops at all ones and does not wrap. A second register holds a programmable threshold. A status output rises whenever the count is at or above that threshold. The threshold compare can be left out with a parameter. The register port has one address bit and a 32-bit data path. Reads are combinational.

Top module: `rst_hold_meter`

## Requirements
- R1: While `porRstN` is low, and after it is released, the count reads 0, the threshold reads all ones of the count width, and `thresholdMet` is 0 (with the default threshold and a zero count).
- R2: Each clock edge at which the pin has been sampled low adds one to the count. The synchroniser adds two edges of latency. After the pin is held low for N edges and then released, the count settles at N (when N is below the maximum).
- R3: While the pin is high, the count holds its value. A later low period adds to the stored value and does not restart from zero.
- R4: The count saturates at 2^CNT_W-1 and stays there while the pin remains low.
- R5: A write to address 0 with data bit 31 set clears the count to 0 at that clock edge.
- R6: A write to address 0 with bit 31 clear leaves the count unchanged.
- R7: When a clear write and an increment fall in the same cycle, the count becomes 0.
- R8: Read data bits at or above CNT_W are always 0, at both addresses.
- R9: A write to address 1 loads the threshold from data bits CNT_W-1:0. A read at address 1 returns that value, and the upper data bits of the write are discarded.
- R10: `thresholdMet` is 1 exactly when the count is greater than or equal to the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| holdPinN | input | 1 | External reset input being measured, active low, asynchronous |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = count, 1 = threshold |
| wrData | input | 32 | Write data; bit 31 at address 0 requests a clear |
| rdData | output | 32 | Read data for the selected register, zero-extended |
| thresholdMet | output | 1 | Count is at or above the threshold |

## Verification
Two events can land on the same edge: the clear write and the increment from a held-low pin. The bench holds the pin low continuously and issues the clear in the middle of the count. It then expects the count to read 0 right after that edge and 1 one edge later, which shows that the clear took priority and that counting carried on. A narrow count width makes saturation reachable, so hold lengths are swept past the maximum and every threshold setting is compared arithmetically against the settled count.

// File: rtl/rst_hold_meter_pkg.sv
package rst_hold_meter_pkg;
  localparam int REG_W = 32;
  localparam int CLR_BIT = 31;

  typedef struct packed {
    logic incr;   // pin sampled low this cycle
    logic clr;    // clear request from register write
    logic thrWr;  // threshold load
  } holdStrb_t;
endpackage

// File: rtl/rst_hold_sync.sv
module rst_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic porRstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) stageQ <= '1;
    else          stageQ <= {stageQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/rst_hold_ctrl.sv
module rst_hold_ctrl
  import rst_hold_meter_pkg::*;
(
  input  logic      holdSyncN,
  input  logic      wrEn,
  input  logic      addr,
  input  logic      clrBit,
  output holdStrb_t strb
);
  always_comb begin
    strb.incr  = ~holdSyncN;
    strb.clr   = wrEn & ~addr & clrBit;
    strb.thrWr = wrEn & addr;
  end
endmodule

// File: rtl/rst_hold_datapath.sv
module rst_hold_datapath
  import rst_hold_meter_pkg::*;
#(
  parameter int CNT_W      = 29,
  parameter bit HAS_THRESH = 1'b1
) (
  input  logic             clk,
  input  logic             porRstN,
  input  holdStrb_t        strb,
  input  logic             addr,
  input  logic [CNT_W-1:0] thrData,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] thrVal,
  output logic             thresholdMet,
  output logic [REG_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] countQ;
  logic             atMax;

  assign atMax = (countQ == CNT_MAX);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                 countQ <= '0;
    else if (strb.clr)            countQ <= '0;
    else if (strb.incr && !atMax) countQ <= countQ + 1'b1;
  end

  assign countVal = countQ;

  generate
    if (HAS_THRESH) begin : g_thr
      logic [CNT_W-1:0] thrQ;
      always_ff @(posedge clk or negedge porRstN) begin
        if (!porRstN)        thrQ <= CNT_MAX;
        else if (strb.thrWr) thrQ <= thrData;
      end
      assign thrVal       = thrQ;
      assign thresholdMet = (countQ >= thrQ);
    end else begin : g_noThr
      logic unusedThr;
      assign unusedThr    = strb.thrWr ^ (^thrData);
      assign thrVal       = '0;
      assign thresholdMet = 1'b0;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    rdData[CNT_W-1:0] = addr ? thrVal : countQ;
  end
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rst_hold_meter_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter bit HAS_THRESH  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             holdPinN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             thresholdMet
);
  logic             holdSyncN;
  holdStrb_t        strb;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] thrVal;

  generate
    if (CNT_W < REG_W - 1) begin : g_spare
      logic unusedWrBits;
      assign unusedWrBits = ^wrData[REG_W-2:CNT_W];
    end
  endgenerate

  rst_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .porRstN (porRstN),
    .asyncIn (holdPinN),
    .syncOut (holdSyncN)
  );

  rst_hold_ctrl u_ctrl (
    .holdSyncN (holdSyncN),
    .wrEn      (wrEn),
    .addr      (addr),
    .clrBit    (wrData[CLR_BIT]),
    .strb      (strb)
  );

  rst_hold_datapath #(.CNT_W(CNT_W), .HAS_THRESH(HAS_THRESH)) u_dp (
    .clk          (clk),
    .porRstN      (porRstN),
    .strb         (strb),
    .addr         (addr),
    .thrData      (wrData[CNT_W-1:0]),
    .countVal     (countVal),
    .thrVal       (thrVal),
    .thresholdMet (thresholdMet),
    .rdData       (rdData)
  );
endmodule

// File: rtl/rst_hold_meter_chk.sv
module rst_hold_meter_chk
  import rst_hold_meter_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             porRstN,
  input holdStrb_t        strb,
  input logic [CNT_W-1:0] countVal,
  input logic [REG_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.incr && !strb.clr && countVal != CNT_MAX) |=> countVal == $past(countVal) + 1'b1);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (countVal == CNT_MAX && !strb.clr) |=> countVal == CNT_MAX);

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!porRstN)
    strb.clr |=> countVal == '0);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!strb.incr && !strb.clr) |=> $stable(countVal));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!porRstN)
    rdData[REG_W-1:CNT_W] == '0);
endmodule

bind rst_hold_meter rst_hold_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .strb     (strb),
  .countVal (countVal),
  .rdData   (rdData)
);

// File: tb/rst_hold_meter_tb.sv
module rst_hold_meter_tb;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        holdPinN = 1'b1;
  logic        wrEn = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        thresholdMet;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_hold_meter #(.CNT_W(CW)) u_dut (
    .clk          (clk),
    .porRstN      (porRstN),
    .holdPinN     (holdPinN),
    .wrEn         (wrEn),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .thresholdMet (thresholdMet)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; addr = 1'b0;
  endtask

  task automatic readReg(logic a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
    addr = 1'b0;
  endtask

  task automatic holdLow(int n);
    if (n > 0) begin
      @(negedge clk);
      holdPinN = 1'b0;
      repeat (n) @(negedge clk);
      holdPinN = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  logic [31:0] rv;

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset
    readReg(1'b0, rv); check("R1 count in reset", rv, 0);
    porRstN = 1'b1;
    repeat (2) @(negedge clk);
    readReg(1'b0, rv); check("R1 count after reset", rv, 0);
    readReg(1'b1, rv); check("R1 threshold after reset", rv, CMAX);
    check("R1 met after reset", {31'b0, thresholdMet}, 0);

    // R2/R4/R5: sweep hold lengths across saturation
    for (int n = 0; n <= CMAX + 6; n++) begin
      regWrite(1'b0, 32'h8000_0000);
      readReg(1'b0, rv); check("R5 clear", rv, 0);
      holdLow(n);
      readReg(1'b0, rv);
      check(n > CMAX ? "R4 saturate" : "R2 length", rv, (n > CMAX) ? CMAX : n);
      check("R8 upper zero", {26'b0, rv[31:CW]} & 32'hFFFF_FFFF, 0);
    end

    // R3: two bursts accumulate, idle holds
    for (int a = 5; a <= 45; a += 20) begin
      for (int b = 3; b <= 33; b += 15) begin
        regWrite(1'b0, 32'h8000_0000);
        holdLow(a);
        repeat (5) @(negedge clk);
        readReg(1'b0, rv); check("R3 idle hold", rv, a);
        holdLow(b);
        readReg(1'b0, rv);
        check("R3 accumulate", rv, (a + b > CMAX) ? CMAX : a + b);
      end
    end

    // R6: writes without bit 31 leave count alone
    regWrite(1'b0, 32'h8000_0000);
    holdLow(17);
    regWrite(1'b0, 32'h7FFF_FFFF);
    regWrite(1'b0, 32'h0000_0000);
    readReg(1'b0, rv); check("R6 no-clear write", rv, 17);

    // R7: clear while counting
    regWrite(1'b0, 32'h8000_0000);
    @(negedge clk); holdPinN = 1'b0;
    repeat (10) @(negedge clk);
    wrEn = 1'b1; addr = 1'b0; wrData = 32'h8000_0000;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    readReg(1'b0, rv); check("R7 clear wins", rv, 0);
    @(negedge clk);
    readReg(1'b0, rv); check("R7 resumes", rv, 1);
    holdPinN = 1'b1;
    repeat (3) @(negedge clk);

    // R9/R10: threshold sweep against several counts
    for (int c = 0; c <= CMAX; c += 9) begin
      regWrite(1'b0, 32'h8000_0000);
      holdLow(c);
      for (int t = 0; t <= CMAX; t++) begin
        regWrite(1'b1, {26'h3AB_CDEF, t[5:0]});
        readReg(1'b1, rv); check("R9 threshold readback", rv, t);
        check("R8 upper zero thr", rv & ~32'(CMAX), 0);
        check("R10 met", {31'b0, thresholdMet}, (c >= t) ? 1 : 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule